// File: doc/BRIEF.md
# Streaming Sector Hamming ECC Unit

This block protects a 256-byte sector of a page-organised flash array with a single-error-correcting code. It accepts the sector as a stream, one byte per accepted cycle. It keeps running parities over the byte address and the bit index, so the whole sector never needs to be held in storage. After the last byte it presents a 22-bit code. The code is made of eleven pairs, and each pair has an even member and an odd member. Three pairs cover the bit index inside a byte. Eight pairs cover the byte address.

Writing a sector uses encode mode: the code produced is stored next to the data in the spare part of the page. Reading it back uses check mode: the stored code is supplied with the start pulse, the data is streamed again, and the freshly computed code is XORed with the stored one. The resulting syndrome is sorted into four outcomes:
- clean;
- one flipped data bit, reported with its byte address and bit index;
- one flipped bit inside the stored code, where the data is good;
- an error that cannot be corrected but is still reported as detected.

The surrounding controller does the actual repair of the buffered byte.

Top module: `ecc_hamming_page`

## Requirements
- R1: In encode mode the code is built as follows. Pair p occupies bits 2p (even member) and 2p+1 (odd member). Pairs 0..2 cover bit index j = p: the even member is the XOR of all data bits whose index has bit j clear, and the odd member is the XOR of all data bits whose index has bit j set. Pairs 3..10 cover byte address bit k = p-3: the even member is the XOR of all bits of bytes whose address has bit k clear, and the odd member is the XOR of all bits of bytes whose address has bit k set. The byte address counts accepted bytes from 0.
- R2: `done` is high for exactly one cycle, starting on the clock edge that accepts the 256th byte. `codeOut`, `status`, `errByte` and `errBit` update on that same edge and hold until the next sector completes.
- R3: A byte is accepted only while `inValid` is high inside a sector. Bytes presented with `inValid` low, before the first `start`, or after the 256th byte of a sector change neither the computed code nor the outputs.
- R4: `start` abandons any sector in progress, clears the running parities and latches `checkMode` and `storedCode`.
- R5: In check mode a computed code equal to the stored code gives status 0 (clean).
- R6: In check mode a single flipped data bit gives status 1. `errByte` then holds the byte address and `errBit` the bit index of the flipped bit, taken from the odd members of the syndrome pairs.
- R7: In check mode a syndrome with exactly one bit set gives status 2, meaning the stored code is damaged and the data is good.
- R8: In check mode any other nonzero syndrome, including every two-bit data error, gives status 3 (uncorrectable).
- R9: In encode mode status is always 0.
- R10: While `status` is not 1, `errByte` and `errBit` are zero.
- R11: After reset `done`, `codeOut`, `status`, `errByte` and `errBit` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sector; latches mode and stored code |
| checkMode | input | 1 | 0 = encode, 1 = check |
| storedCode | input | 22 | Code read back from the spare area (check mode) |
| inValid | input | 1 | Qualifies inData |
| inData | input | 8 | Sector byte |
| done | output | 1 | One-cycle result strobe |
| codeOut | output | 22 | Computed code for the sector |
| status | output | 2 | 0 clean, 1 data bit fixable, 2 code bit flipped, 3 uncorrectable |
| errByte | output | 8 | Byte address of the failing bit (status 1) |
| errBit | output | 3 | Bit index of the failing bit (status 1) |

## Verification
The embedded properties watch the things that hold on every cycle:
- the single-cycle shape of `done` and its tie to the final-byte strobe;
- the clearing of the running parities after `start`;
- the byte counter freezing outside a sector;
- the zeroed location fields whenever the status is not a fixable data error;
- the clean status in encode mode.

Only the bench scenarios can show that the code and syndrome classification are arithmetically right. They cover:
- exact code values across several data patterns and with idle gaps;
- correct byte and bit location across a spread of single flips that includes the first and last bit;
- all 22 stored-code flips;
- double flips, including a complementary pair;
- ignored bytes before start and after the end;
- a restart part-way through a sector.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_FIXABLE  = 2'd1,
    ST_CODE_BIT = 2'd2,
    ST_FATAL    = 2'd3
  } eccStatus_e;

  typedef struct packed {
    logic clear;
    logic accumulate;
    logic finish;
  } eccStrobes_t;

endpackage

// File: rtl/ecc_seq_ctrl.sv
module ecc_seq_ctrl
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  output eccStrobes_t       strobes,
  output logic [ADDR_W-1:0] byteIdx
);

  localparam logic [ADDR_W-1:0] LAST_IDX = '1;

  logic              active;
  logic [ADDR_W-1:0] byteCount;
  logic              takeByte;

  assign takeByte           = active && inValid && !start;
  assign strobes.clear      = start;
  assign strobes.accumulate = takeByte;
  assign strobes.finish     = takeByte && (byteCount == LAST_IDX);
  assign byteIdx            = byteCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      byteCount <= '0;
    end else if (start) begin
      active    <= 1'b1;
      byteCount <= '0;
    end else if (takeByte) begin
      byteCount <= byteCount + 1'b1;
      if (byteCount == LAST_IDX) active <= 1'b0;
    end
  end

  // R3: outside a sector the byte position does not move
  a_r3_idle_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !start) |=> $stable(byteCount));

  // R2: the final byte closes the sector
  a_r2_finish_closes: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> !active);

  // R4: start always opens a fresh sector at position zero
  a_r4_start_rewinds: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (active && byteCount == '0));

endmodule

// File: rtl/ecc_parity_path.sv
module ecc_parity_path
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  eccStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   byteIdx,
  input  logic                checkMode,
  input  logic [2*(ADDR_W+$clog2(DATA_W))-1:0] storedCode,
  input  logic [DATA_W-1:0]   inData,
  output logic                done,
  output logic [2*(ADDR_W+$clog2(DATA_W))-1:0] codeOut,
  output eccStatus_e          status,
  output logic [ADDR_W-1:0]   errByte,
  output logic [$clog2(DATA_W)-1:0] errBit
);

  localparam int BIT_W  = $clog2(DATA_W);
  localparam int PAIRS  = ADDR_W + BIT_W;
  localparam int CODE_W = 2 * PAIRS;

  function automatic logic [DATA_W-1:0] colMask(input int j);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((i >> j) & 1) == 1;
    return m;
  endfunction

  logic [ADDR_W-1:0] lineEven, lineOdd, lineEvenN, lineOddN;
  logic [BIT_W-1:0]  colEven, colOdd, colEvenN, colOddN;
  logic [BIT_W-1:0]  colParE, colParO;
  logic              bytePar;
  logic              modeReg;
  logic [CODE_W-1:0] storedReg;
  logic [CODE_W-1:0] codeN, syndrome;
  logic [PAIRS-1:0]  pairDiff;
  logic [ADDR_W-1:0] locByte;
  logic [BIT_W-1:0]  locBit;
  eccStatus_e        classN;

  assign bytePar = ^inData;

  for (genvar j = 0; j < BIT_W; j++) begin : g_col
    assign colParO[j] = ^(inData & colMask(j));
    assign colParE[j] = ^(inData & ~colMask(j));
  end

  always_comb begin
    lineEvenN = lineEven;
    lineOddN  = lineOdd;
    colEvenN  = colEven;
    colOddN   = colOdd;
    if (strobes.accumulate) begin
      lineOddN  = lineOdd ^ ({ADDR_W{bytePar}} & byteIdx);
      lineEvenN = lineEven ^ ({ADDR_W{bytePar}} & ~byteIdx);
      colOddN   = colOdd ^ colParO;
      colEvenN  = colEven ^ colParE;
    end
  end

  for (genvar p = 0; p < BIT_W; p++) begin : g_pack_col
    assign codeN[2*p]   = colEvenN[p];
    assign codeN[2*p+1] = colOddN[p];
  end
  for (genvar k = 0; k < ADDR_W; k++) begin : g_pack_line
    assign codeN[2*(BIT_W+k)]   = lineEvenN[k];
    assign codeN[2*(BIT_W+k)+1] = lineOddN[k];
  end

  assign syndrome = codeN ^ storedReg;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pairDiff[p] = syndrome[2*p] ^ syndrome[2*p+1];
  end
  for (genvar j = 0; j < BIT_W; j++) begin : g_loc_bit
    assign locBit[j] = syndrome[2*j+1];
  end
  for (genvar k = 0; k < ADDR_W; k++) begin : g_loc_byte
    assign locByte[k] = syndrome[2*(BIT_W+k)+1];
  end

  always_comb begin
    if (!modeReg || syndrome == '0)
      classN = ST_CLEAN;
    else if (&pairDiff)
      classN = ST_FIXABLE;
    else if ((syndrome & (syndrome - 1'b1)) == '0)
      classN = ST_CODE_BIT;
    else
      classN = ST_FATAL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineEven  <= '0;
      lineOdd   <= '0;
      colEven   <= '0;
      colOdd    <= '0;
      modeReg   <= 1'b0;
      storedReg <= '0;
    end else if (strobes.clear) begin
      lineEven  <= '0;
      lineOdd   <= '0;
      colEven   <= '0;
      colOdd    <= '0;
      modeReg   <= checkMode;
      storedReg <= storedCode;
    end else begin
      lineEven  <= lineEvenN;
      lineOdd   <= lineOddN;
      colEven   <= colEvenN;
      colOdd    <= colOddN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      codeOut <= '0;
      status  <= ST_CLEAN;
      errByte <= '0;
      errBit  <= '0;
    end else begin
      done <= strobes.finish;
      if (strobes.finish) begin
        codeOut <= codeN;
        status  <= classN;
        errByte <= (classN == ST_FIXABLE) ? locByte : '0;
        errBit  <= (classN == ST_FIXABLE) ? locBit : '0;
      end
    end
  end

  // R2: done is a single-cycle strobe following the last-byte strobe
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r2_done_from_finish: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(strobes.finish));

  // R4: start leaves the running parities empty
  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (lineEven == '0 && lineOdd == '0 && colEven == '0 && colOdd == '0));

  // R9: encode mode never reports an error
  a_r9_encode_clean: assert property (@(posedge clk) disable iff (!rstN)
    (done && !modeReg) |-> status == ST_CLEAN);

  // R10: location fields are zero unless a data bit is fixable
  a_r10_loc_zero: assert property (@(posedge clk) disable iff (!rstN)
    (status != ST_FIXABLE) |-> (errByte == '0 && errBit == '0));

  // R2: results hold between sector completions
  a_r2_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> ($stable(codeOut) && $stable(status)));

endmodule

// File: rtl/ecc_hamming_page.sv
module ecc_hamming_page
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int CODE_W = 2 * (ADDR_W + BIT_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              checkMode,
  input  logic [CODE_W-1:0] storedCode,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              done,
  output logic [CODE_W-1:0] codeOut,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] errByte,
  output logic [BIT_W-1:0]  errBit
);

  eccStrobes_t       strobes;
  logic [ADDR_W-1:0] byteIdx;
  eccStatus_e        statusE;

  ecc_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .inValid (inValid),
    .strobes (strobes),
    .byteIdx (byteIdx)
  );

  ecc_parity_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .byteIdx    (byteIdx),
    .checkMode  (checkMode),
    .storedCode (storedCode),
    .inData     (inData),
    .done       (done),
    .codeOut    (codeOut),
    .status     (statusE),
    .errByte    (errByte),
    .errBit     (errBit)
  );

  assign status = statusE;

endmodule

// File: tb/sim_ecc_hamming_page.sv
`timescale 1ns/1ps
module sim_ecc_hamming_page;

  localparam int NB = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        checkMode = 1'b0;
  logic [21:0] storedCode = '0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        done;
  logic [21:0] codeOut;
  logic [1:0]  status;
  logic [7:0]  errByte;
  logic [2:0]  errBit;

  int checks = 0;
  int failures = 0;

  logic [7:0]  sector [NB];
  logic        gotDone, doneAfter;
  logic [21:0] gotCode;
  logic [1:0]  gotStatus;
  logic [7:0]  gotByte;
  logic [2:0]  gotBit;

  always #2 clk = ~clk;

  ecc_hamming_page u0 (
    .clk(clk), .rstN(rstN), .start(start), .checkMode(checkMode),
    .storedCode(storedCode), .inValid(inValid), .inData(inData),
    .done(done), .codeOut(codeOut), .status(status),
    .errByte(errByte), .errBit(errBit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] goldCode();
    logic [21:0] c = '0;
    for (int a = 0; a < NB; a++)
      for (int b = 0; b < 8; b++)
        if (sector[a][b]) begin
          for (int j = 0; j < 3; j++) c[2*j + ((b >> j) & 1)] ^= 1'b1;
          for (int k = 0; k < 8; k++) c[2*(3+k) + ((a >> k) & 1)] ^= 1'b1;
        end
    return c;
  endfunction

  task automatic fillSector(input int seed);
    for (int i = 0; i < NB; i++) begin
      if (seed == 0) sector[i] = 8'h00;
      else if (seed == 1) sector[i] = 8'hFF;
      else sector[i] = 8'((i * (2*seed + 1)) ^ (seed * 29) ^ (i >> 3));
    end
  endtask

  // flip positions are byte*8+bit, -1 for none
  task automatic runSector(input logic mode, input logic [21:0] stored,
                           input int gapEvery, input int flipA, input int flipB);
    @(negedge clk);
    start = 1'b1; checkMode = mode; storedCode = stored; inValid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < NB; i++) begin
      logic [7:0] d;
      if (gapEvery > 0 && (i % gapEvery) == 0) begin
        inValid = 1'b0; inData = 8'h5A ^ 8'(i);
        @(negedge clk);
      end
      d = sector[i];
      if (flipA >= 0 && (flipA / 8) == i) d[flipA % 8] ^= 1'b1;
      if (flipB >= 0 && (flipB / 8) == i) d[flipB % 8] ^= 1'b1;
      inValid = 1'b1; inData = d;
      @(negedge clk);
    end
    inValid = 1'b0;
    gotDone = done; gotCode = codeOut; gotStatus = status;
    gotByte = errByte; gotBit = errBit;
    @(negedge clk);
    doneAfter = done;
  endtask

  task automatic feedLoose(input int n);
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1; inData = 8'(i * 7 + 3);
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [21:0] ref_code;
    logic [21:0] keep;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 done", 32'(done), 0);
    chk("R11 code", 32'(codeOut), 0);
    chk("R11 status", 32'(status), 0);
    chk("R11 loc", {errByte, errBit}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: bytes before any start are ignored
    feedLoose(20);
    chk("R3 no done before start", 32'(done), 0);
    chk("R3 code untouched before start", 32'(codeOut), 0);

    // R1, R2, R9: encode sweep
    for (int s = 0; s < 6; s++) begin
      fillSector(s);
      ref_code = goldCode();
      runSector(1'b0, 22'h3FFFFF, (s == 3) ? 5 : 0, -1, -1);
      chk("R2 done after last byte", 32'(gotDone), 1);
      chk("R2 done single cycle", 32'(doneAfter), 0);
      chk(s == 3 ? "R3 code with idle gaps" : "R1 encode code", 32'(gotCode), 32'(ref_code));
      chk("R9 encode status", 32'(gotStatus), 0);
    end

    // R3: bytes after the 256th are ignored
    keep = codeOut;
    feedLoose(8);
    chk("R3 no done after end", 32'(done), 0);
    chk("R3 code held after end", 32'(codeOut), 32'(keep));

    // R4: restart mid-sector
    fillSector(4);
    ref_code = goldCode();
    @(negedge clk);
    start = 1'b1; checkMode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    feedLoose(100);
    runSector(1'b0, '0, 0, -1, -1);
    chk("R4 restart code", 32'(gotCode), 32'(ref_code));
    chk("R4 restart done", 32'(gotDone), 1);

    // R5: clean check
    for (int s = 2; s < 4; s++) begin
      fillSector(s);
      ref_code = goldCode();
      runSector(1'b1, ref_code, 0, -1, -1);
      chk("R5 clean status", 32'(gotStatus), 0);
      chk("R10 clean loc zero", {gotByte, gotBit}, 0);
    end

    // R6: single data bit errors
    for (int e = 0; e < 50; e++) begin
      int pos;
      pos = (e == 0) ? 0 : (e == 1) ? 2047 : (e * 173 + 5) % 2048;
      fillSector(e % 6);
      ref_code = goldCode();
      runSector(1'b1, ref_code, 0, pos, -1);
      chk("R6 fixable status", 32'(gotStatus), 1);
      chk("R6 byte location", 32'(gotByte), 32'(pos / 8));
      chk("R6 bit location", 32'(gotBit), 32'(pos % 8));
    end

    // R7: single flipped bit in stored code
    fillSector(5);
    ref_code = goldCode();
    for (int b = 0; b < 22; b++) begin
      runSector(1'b1, ref_code ^ (22'd1 << b), 0, -1, -1);
      chk("R7 code bit status", 32'(gotStatus), 2);
      chk("R10 code bit loc zero", {gotByte, gotBit}, 0);
    end

    // R8: double data bit errors
    fillSector(2);
    ref_code = goldCode();
    for (int e = 0; e < 8; e++) begin
      int pa, pb;
      pa = (e * 311 + 17) % 2048;
      pb = (pa + 1 + e * 97) % 2048;
      runSector(1'b1, ref_code, 0, pa, pb);
      chk("R8 double error status", 32'(gotStatus), 3);
      chk("R10 fatal loc zero", {gotByte, gotBit}, 0);
    end
    // complementary positions: every pair differs in both members
    runSector(1'b1, ref_code, 0, 0, 2047);
    chk("R8 complementary double", 32'(gotStatus), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule